// File: doc/BRIEF.md
# Signed 64/32 Register-Mapped Divider

This block is an integer division unit that a processor drives through a small 32-bit register bus with per-byte write enables. Software loads a divisor and a dividend. Writing the last dividend word starts a signed division that runs one quotient bit per clock. The result comes back in place: the quotient replaces the word that started the operation, and the remainder replaces the upper dividend word.

There are two ways to start. A 64-bit dividend is split into an upper word and a lower word, and writing the lower word starts a 64÷32 operation. A separate 32-bit dividend word starts a 32÷32 operation. That write also fills the upper word with copies of the written value's sign bit.

Some results cannot be represented. When the divisor is zero, or the quotient does not fit in signed 32 bits, the unit saturates the quotient and sets a sticky fault flag. When enabled, the flag raises an interrupt request that carries a vector number programmed by software. Reads and writes of the operand and result words stall the bus while the unit is busy, so software never sees a half-finished result.

Top module: `sdiv_unit`

## Requirements
- R1: The vector register (word index 3) keeps only bits 6:0. Those bits are written through byte lane 0, so a full-word or a halfword access both reach them. Bits 31:7 always read 0. The stored value drives `irq_vector`.
- R2: A write to the 32-bit dividend word (index 1) fills the upper dividend word with 32 copies of the written bit 31. It then starts a signed 32÷32 division of that value by the divisor (index 0). On completion the quotient replaces index 1 and the remainder replaces the upper word (index 4).
- R3: A write to the upper dividend word (index 4) does not start a division. A write to the lower dividend word (index 5) starts a signed 64÷32 division of {index 4, index 5} by the divisor. On completion the quotient replaces index 5 and the remainder replaces index 4. The quotient truncates toward zero, and the remainder takes the dividend's sign.
- R4: If the divisor is zero, or the true quotient lies outside [-2^31, 2^31-1], the operation is a fault. The quotient is then saturated: to 0x7FFFFFFF when dividend sign XOR divisor sign is 0, and to 0x80000000 otherwise. The upper dividend word keeps its pre-division value.
- R5: Control register (index 2) bit 1 is a sticky fault flag, set by every fault. Later divisions that complete normally do not clear it. Writing 0 to bit 1 through lane 0 clears it, and writing 1 there has no effect.
- R6: `irq_req` equals control bit 0 (interrupt enable) AND the fault flag.
- R7: Control bit 2 reads 1 from the first access after a start until the result has been written back.
- R8: While busy, any access to indices 0, 1, 4 or 5 keeps `bus_ready` low until the writeback. A write that is held in this way takes effect afterwards and does not alter the division in flight. Control and vector accesses are never stalled.
- R9: After reset, the control register, divisor, 32-bit dividend and lower dividend words read 0, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (3) | Word index of the register |
| bus_be | input | DW/8 (4) | Byte-lane write enables |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid while `bus_sel` and `bus_ready` |
| bus_ready | output | 1 | Access completes on the clock edge where this is high |
| irq_req | output | 1 | Interrupt request for a divide fault |
| irq_vector | output | VEC_W (7) | Vector number sent with the request |

## Verification
The bench builds the unit with its default parameters: DW = 32, AW = 3 and VEC_W = 7. At these values the full signed corners can be reached: the most negative 32-bit and 64-bit operands, the quotients exactly at +2^31-1 and -2^31, and the first value just past the positive limit. Each operation runs 32 iterations, so the busy window is long enough for a held divisor write and an early control read to fall inside it. This exercises the stall and in-flight isolation of R7 and R8.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [2:0] {
    REG_DIVISOR = 3'd0,
    REG_DVD32   = 3'd1,
    REG_CTRL    = 3'd2,
    REG_VEC     = 3'd3,
    REG_DVDHI   = 3'd4,
    REG_DVDLO   = 3'd5
  } reg_idx_e;

  localparam int CTRL_IE_BIT   = 0;
  localparam int CTRL_OVF_BIT  = 1;
  localparam int CTRL_BUSY_BIT = 2;
endpackage

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dvd_hi,
  input  logic [DW-1:0] dvd_lo,
  input  logic [DW-1:0] divisor,
  output logic          running,
  output logic          done,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          ovf
);
  localparam int CW = $clog2(DW) + 1;
  localparam logic [DW-1:0] MIN_MAG = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [2*DW-1:0] mag2(input logic [2*DW-1:0] v);
    return v[2*DW-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [DW-1:0] mag1(input logic [DW-1:0] v);
    return v[DW-1] ? (~v + 1'b1) : v;
  endfunction

  // One shift-subtract step on magnitudes: returns {next_rem, next_quo}.
  function automatic logic [2*DW-1:0] shift_sub(input logic [DW-1:0] r,
                                                 input logic [DW-1:0] q,
                                                 input logic [DW-1:0] d);
    logic [DW:0] t;
    logic        b;
    t = {r, q[DW-1]};
    b = 1'b0;
    if (t >= {1'b0, d}) begin
      t = t - {1'b0, d};
      b = 1'b1;
    end
    return {t[DW-1:0], q[DW-2:0], b};
  endfunction

  logic [CW-1:0]   cnt;
  logic [DW-1:0]   rem_r, q_r, d_mag;
  logic            n_neg, d_neg, pre_ovf, fin;
  logic [2*DW-1:0] n_mag_in;
  logic [DW-1:0]   d_mag_in;
  logic            q_neg, q_fits;

  assign n_mag_in = mag2({dvd_hi, dvd_lo});
  assign d_mag_in = mag1(divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      fin     <= 1'b0;
      cnt     <= '0;
      rem_r   <= '0;
      q_r     <= '0;
      d_mag   <= '0;
      n_neg   <= 1'b0;
      d_neg   <= 1'b0;
      pre_ovf <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
        rem_r   <= n_mag_in[2*DW-1:DW];
        q_r     <= n_mag_in[DW-1:0];
        d_mag   <= d_mag_in;
        n_neg   <= dvd_hi[DW-1];
        d_neg   <= divisor[DW-1];
        pre_ovf <= (divisor == '0) || (n_mag_in[2*DW-1:DW] >= d_mag_in);
      end else if (running) begin
        {rem_r, q_r} <= shift_sub(rem_r, q_r, d_mag);
        cnt          <= cnt + 1'b1;
        if (cnt == CW'(DW-1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end

  assign q_neg  = n_neg ^ d_neg;
  assign q_fits = q_neg ? (q_r <= MIN_MAG) : ~q_r[DW-1];
  assign ovf    = pre_ovf | ~q_fits;
  assign quo    = ovf ? (q_neg ? MIN_MAG : ~MIN_MAG) : (q_neg ? (~q_r + 1'b1) : q_r);
  assign rem    = n_neg ? (~rem_r + 1'b1) : rem_r;
  assign done   = fin;

  // R3: a normal result leaves a remainder smaller than the divisor
  assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !ovf) |-> (rem_r < d_mag));

  // R7: a result only appears right after the iteration phase
  assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(running));
endmodule

// File: rtl/sdiv_irq.sv
module sdiv_irq #(
  parameter int VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [1:0]       ctrl_wdata,
  input  logic             vec_wr,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic             set_ovf,
  output logic             irq_en,
  output logic             ovf_flag,
  output logic [VEC_W-1:0] vec,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec
);
  import sdiv_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (ctrl_wr) irq_en <= ctrl_wdata[CTRL_IE_BIT];
      if (set_ovf) ovf_flag <= 1'b1;
      else if (ctrl_wr && !ctrl_wdata[CTRL_OVF_BIT]) ovf_flag <= 1'b0;
    end
  end

  // Vector number is deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (vec_wr) vec <= vec_wdata;
  end

  assign irq     = irq_en & ovf_flag;
  assign irq_vec = vec;

  // R5: the flag only rises because a faulting division completed
  assert_flag_from_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(set_ovf));
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW/8-1:0]  bus_be,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_ready,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector
);
  import sdiv_pkg::*;

  localparam int BW = DW / 8;
  localparam logic [DW-1:0] SAT_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SAT_NEG = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                               input logic [DW-1:0] wd,
                                               input logic [BW-1:0] be);
    logic [DW-1:0] m;
    m = old;
    for (int i = 0; i < BW; i++)
      if (be[i]) m[i*8 +: 8] = wd[i*8 +: 8];
    return m;
  endfunction

  reg_idx_e      idx;
  logic          busy, start_q, mode64_r;
  logic [DW-1:0] divisor_r, q32_r, lo_r, hi_r;
  logic [DW-1:0] q32_next;
  logic          operand_acc, acc_fire, wr_fire;
  logic          wr_divisor, wr_dvd32, wr_hi, wr_lo, wr_ctrl, wr_vec;
  logic          core_running, core_done, core_ovf;
  logic [DW-1:0] core_quo, core_rem;
  logic          wb_fire;
  logic          irq_en, ovf_flag;
  logic [VEC_W-1:0] vec;

  assign idx = reg_idx_e'(bus_addr[2:0]);

  assign operand_acc = (idx == REG_DIVISOR) || (idx == REG_DVD32) ||
                       (idx == REG_DVDHI)   || (idx == REG_DVDLO);
  assign busy      = start_q | core_running | core_done;
  assign bus_ready = ~(operand_acc & busy);
  assign acc_fire  = bus_sel & bus_ready;
  assign wr_fire   = acc_fire & bus_wr;

  assign wr_divisor = wr_fire && (idx == REG_DIVISOR);
  assign wr_dvd32   = wr_fire && (idx == REG_DVD32);
  assign wr_hi      = wr_fire && (idx == REG_DVDHI);
  assign wr_lo      = wr_fire && (idx == REG_DVDLO);
  assign wr_ctrl    = wr_fire && (idx == REG_CTRL) && bus_be[0];
  assign wr_vec     = wr_fire && (idx == REG_VEC) && bus_be[0];
  assign wb_fire    = core_done;

  assign q32_next = lane_merge(q32_r, bus_wdata, bus_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor_r <= '0;
      q32_r     <= '0;
      lo_r      <= '0;
      start_q   <= 1'b0;
      mode64_r  <= 1'b0;
    end else begin
      start_q <= wr_dvd32 | wr_lo;
      if (wr_divisor) divisor_r <= lane_merge(divisor_r, bus_wdata, bus_be);
      if (wr_dvd32) begin
        q32_r    <= q32_next;
        mode64_r <= 1'b0;
      end
      if (wr_lo) begin
        lo_r     <= lane_merge(lo_r, bus_wdata, bus_be);
        mode64_r <= 1'b1;
      end
      if (wb_fire) begin
        if (mode64_r) lo_r <= core_quo;
        else          q32_r <= core_quo;
      end
    end
  end

  // Upper dividend word is deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (wr_hi)         hi_r <= lane_merge(hi_r, bus_wdata, bus_be);
    else if (wr_dvd32) hi_r <= {DW{q32_next[DW-1]}};
    else if (wb_fire && !core_ovf) hi_r <= core_rem;
  end

  sdiv_core #(.DW(DW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_q),
    .dvd_hi  (hi_r),
    .dvd_lo  (mode64_r ? lo_r : q32_r),
    .divisor (divisor_r),
    .running (core_running),
    .done    (core_done),
    .quo     (core_quo),
    .rem     (core_rem),
    .ovf     (core_ovf)
  );

  sdiv_irq #(.VEC_W(VEC_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (wr_ctrl),
    .ctrl_wdata (bus_wdata[1:0]),
    .vec_wr     (wr_vec),
    .vec_wdata  (bus_wdata[VEC_W-1:0]),
    .set_ovf    (wb_fire & core_ovf),
    .irq_en     (irq_en),
    .ovf_flag   (ovf_flag),
    .vec        (vec),
    .irq        (irq_req),
    .irq_vec    (irq_vector)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (idx)
      REG_DIVISOR: bus_rdata = divisor_r;
      REG_DVD32:   bus_rdata = q32_r;
      REG_CTRL: begin
        bus_rdata[CTRL_IE_BIT]   = irq_en;
        bus_rdata[CTRL_OVF_BIT]  = ovf_flag;
        bus_rdata[CTRL_BUSY_BIT] = busy;
      end
      REG_VEC:     bus_rdata[VEC_W-1:0] = vec;
      REG_DVDHI:   bus_rdata = hi_r;
      REG_DVDLO:   bus_rdata = lo_r;
      default:     bus_rdata = '0;
    endcase
  end

  // R1: unused vector bits never show on a read
  assert_vec_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && idx == REG_VEC) |-> (bus_rdata[DW-1:VEC_W] == '0));

  // R2: a 32-bit dividend write leaves the upper word as its sign
  assert_sign_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dvd32 |=> (hi_r == {DW{q32_r[DW-1]}}));

  // R4: a faulting division writes a saturated quotient and keeps the upper word
  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && core_ovf) |=> (((mode64_r ? lo_r : q32_r) == SAT_POS) ||
                               ((mode64_r ? lo_r : q32_r) == SAT_NEG)) && $stable(hi_r));

  // R8: control and vector accesses always complete at once
  assert_ctrl_never_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (idx == REG_CTRL || idx == REG_VEC)) |-> bus_ready);
endmodule

// File: tb/sdiv_unit_bench.sv
module sdiv_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, irq;
  logic [6:0]  irqv;

  int checks = 0;
  int errors = 0;
  bit exp_flag = 0;

  typedef struct {
    bit          m64;
    logic [31:0] q;
    logic [31:0] r;
    bit          ovf;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdiv_unit u_sdiv_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready),
    .irq_req(irq), .irq_vector(irqv)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_acc(input logic w, input logic [2:0] a, input logic [31:0] wd,
                         input logic [3:0] b, output logic [31:0] rd, output int waits);
    @(negedge clk);
    sel = 1'b1; wr = w; addr = a; wdata = wd; be = b; waits = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = rdata;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic wr32(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] rd; int w;
    bus_acc(1'b1, a, d, 4'hF, rd, w);
  endtask

  task automatic rd32(input logic [2:0] a, output logic [31:0] d, output int w);
    bus_acc(1'b0, a, 32'h0, 4'h0, d, w);
  endtask

  // Driver: works out the expected result from R2/R3/R4, queues it, starts the unit.
  task automatic drive_div(input bit m64, input logic [31:0] hi, input logic [31:0] lo,
                           input logic [31:0] d, input string tag);
    exp_t e;
    longint n, dd, q, r;
    bit neg;
    n  = m64 ? longint'({hi, lo}) : longint'({{32{lo[31]}}, lo});
    dd = longint'({{32{d[31]}}, d});
    neg = n[63] ^ d[31];
    e.ovf = 0; q = 0; r = 0;
    if (dd == 0 || (n == 64'sh8000000000000000 && dd == -1)) e.ovf = 1;
    else begin
      q = n / dd;
      r = n % dd;
      e.ovf = (q > 64'sd2147483647) || (q < -64'sd2147483648);
    end
    e.q = e.ovf ? (neg ? 32'h80000000 : 32'h7FFFFFFF) : q[31:0];
    e.r = e.ovf ? n[63:32] : r[31:0];
    e.m64 = m64;
    e.tag = tag;
    wr32(3'd0, d);
    if (m64) begin
      wr32(3'd4, hi);
      wr32(3'd5, lo);
    end else begin
      wr32(3'd1, lo);
    end
    sb.push_back(e);
  endtask

  // Monitor: pops the oldest expectation and compares it against the bus results.
  task automatic collect(output int qwaits);
    exp_t e;
    logic [31:0] v; int w;
    e = sb.pop_front();
    rd32(e.m64 ? 3'd5 : 3'd1, v, qwaits);
    check(v == e.q, {e.tag, " quotient"}, v, e.q);
    rd32(3'd4, v, w);
    check(v == e.r, {e.tag, " remainder/upper"}, v, e.r);
    if (e.ovf) exp_flag = 1;
    rd32(3'd2, v, w);
    check(v[1] == exp_flag, {e.tag, " R5 sticky flag"}, {31'd0, v[1]}, {31'd0, exp_flag});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v; int w, qw;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd32(3'd2, v, w); check(v == 32'h0, "R9 ctrl after reset", v, 32'h0);
    rd32(3'd0, v, w); check(v == 32'h0, "R9 divisor after reset", v, 32'h0);
    rd32(3'd5, v, w); check(v == 32'h0, "R9 low word after reset", v, 32'h0);
    check(irq == 1'b0, "R9 irq after reset", {31'd0, irq}, 32'h0);

    // R1 vector register
    wr32(3'd3, 32'hFFFF_FFFF);
    rd32(3'd3, v, w); check(v == 32'h7F, "R1 vector full write", v, 32'h7F);
    bus_acc(1'b1, 3'd3, 32'h0000_1234, 4'h3, v, w);
    rd32(3'd3, v, w); check(v == 32'h34, "R1 vector halfword write", v, 32'h34);
    check(irqv == 7'h34, "R1 irq_vector port", {25'd0, irqv}, 32'h34);

    // R3 64-bit signed cases
    drive_div(1, 32'h0, 32'd100, 32'd7, "R3 pos/pos");
    collect(qw);
    check(qw > 0, "R8 quotient read stalled", qw, 1);
    drive_div(1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, "R3 neg/pos");
    collect(qw);
    drive_div(1, 32'h1, 32'h0, 32'hFFFF_FFFD, "R3 pos/neg");
    collect(qw);
    drive_div(1, 32'hFFFF_FEFF, 32'hFFFF_FFFB, 32'hFFFF_FC18, "R3 neg/neg");
    collect(qw);
    drive_div(1, 32'h2, 32'h7FFF_FFFF, 32'd5, "R4 positive limit fits");
    collect(qw);
    drive_div(1, 32'hFFFF_FFFE, 32'h8000_0000, 32'd3, "R4 negative limit fits");
    collect(qw);

    // R2 sign fill: an upper word of garbage must be replaced
    wr32(3'd4, 32'h1234_5678);
    drive_div(0, 32'h0, 32'hFFFF_FFF9, 32'd2, "R2 32-bit neg");
    collect(qw);
    drive_div(0, 32'h0, 32'd1000, 32'hFFFF_FFDF, "R2 32-bit pos/neg");
    collect(qw);

    // R7 busy bit and R8 held divisor write
    drive_div(1, 32'h0, 32'd5000, 32'd9, "R8 in-flight isolation");
    rd32(3'd2, v, w);
    check(v[2] == 1'b1, "R7 busy bit after start", {31'd0, v[2]}, 32'h1);
    check(w == 0, "R8 ctrl not stalled", w, 0);
    bus_acc(1'b1, 3'd0, 32'd1, 4'hF, v, w);
    check(w > 0, "R8 divisor write stalled", w, 1);
    collect(qw);
    rd32(3'd0, v, w); check(v == 32'd1, "R8 held write applied", v, 32'd1);
    rd32(3'd2, v, w); check(v[2] == 1'b0, "R7 busy clear after writeback", {31'd0, v[2]}, 32'h0);

    // R4 faults
    drive_div(1, 32'h1, 32'h8000_0000, 32'd3, "R4 just past positive limit");
    collect(qw);
    check(irq == 1'b0, "R6 irq gated by enable", {31'd0, irq}, 32'h0);
    drive_div(1, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 32'd0, "R4 divide by zero");
    collect(qw);
    drive_div(0, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, "R4 32-bit min by -1");
    collect(qw);

    // R5 flag stays through a good division
    drive_div(1, 32'h0, 32'd9, 32'd3, "R5 good division after fault");
    collect(qw);

    // R5/R6 flag and interrupt control
    wr32(3'd2, 32'h3);
    check(irq == 1'b1, "R6 irq with enable and flag", {31'd0, irq}, 32'h1);
    check(irqv == 7'h34, "R6 vector with request", {25'd0, irqv}, 32'h34);
    rd32(3'd2, v, w); check(v[1:0] == 2'b11, "R5 writing 1 keeps flag", {30'd0, v[1:0]}, 32'h3);
    wr32(3'd2, 32'h1);
    exp_flag = 0;
    rd32(3'd2, v, w); check(v[1:0] == 2'b01, "R5 writing 0 clears flag", {30'd0, v[1:0]}, 32'h1);
    check(irq == 1'b0, "R6 irq drops with flag", {31'd0, irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule